// File: doc/BRIEF.md
# Bus-Attached ALU with Carry Status Register

This block is the arithmetic and logic stage of a small CPU built around one shared 8-bit tri-state data bus. It takes two operands, `aIn` and `bIn`, from the CPU's operand registers. Three results come out of it: a sum, an XOR-conditioned copy of B, and a bitwise AND. Any one of them can be placed on the bus. One XOR stage does two jobs. When `subMode` is high it inverts every bit of B and the adder's carry-in is forced to 1, so the single adder computes A minus B in two's complement. The same conditioned B can also be driven onto the bus, which gives an invert operation.

A 4-bit status register holds the adder's carry in bit 0, and its other bits are always 0. The register has its own output enable, so it shares the same bus output as the results. It loads only on clock edges where `flagLoad` is high. The carry therefore becomes visible one cycle after the add. This fits a two-cycle instruction: the first cycle computes the result and the second cycle latches the flag.

Top module: `busAlu`

## Requirements
- R1: With `subMode` low, the sum is `aIn + bIn` modulo 256, and `carryOut` is the ninth bit of that sum, driven combinationally in the same cycle.
- R2: With `subMode` high, the sum is `aIn - bIn` modulo 256, formed as A plus inverted B plus a carry-in of 1. `carryOut` is 1 exactly when `aIn >= bIn` (no borrow).
- R3: With `invEn` as the only enable, the bus carries `bIn` XOR 8 copies of `subMode`. This is the inverted B when `subMode` is high and B unchanged when it is low.
- R4: With `andEn` as the only enable, the bus carries `aIn & bIn`.
- R5: With none of `sumEn`, `invEn`, `andEn` and `flagEn` high, all 8 bus bits are high-impedance.
- R6: If two or more of those four enables are high in the same cycle, nothing drives the bus and all bits are high-impedance.
- R7: With `flagEn` as the only enable, the bus carries the status register: the stored carry in bit 0 and 0 in bits 7 to 1.
- R8: On a rising edge with `flagLoad` high and `rst` low, the stored carry takes the `carryOut` value of that cycle. During the loading cycle itself the bus still shows the old flag.
- R9: On a rising edge with `flagLoad` low and `rst` low, the stored carry keeps its value.
- R10: On a rising edge with `rst` high, the status register clears to 0, even when `flagLoad` is also high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, clears the status register |
| aIn | input | 8 | Operand A |
| bIn | input | 8 | Operand B, fed through the XOR stage |
| subMode | input | 1 | Inverts B and sets the adder carry-in to 1 |
| sumEn | input | 1 | Drive the adder result onto the bus |
| invEn | input | 1 | Drive the XOR-stage output onto the bus |
| andEn | input | 1 | Drive A AND B onto the bus |
| flagEn | input | 1 | Drive the status register onto the bus |
| flagLoad | input | 1 | Latch the carry on the next rising edge |
| carryOut | output | 1 | Combinational adder carry-out |
| dataBus | inout | 8 | Shared tri-state data bus |

## Verification
The bench reads the flag back in the same cycle that `flagLoad` is high, and again in the next cycle. A design that made the flag transparent would show the new carry one cycle early. Subtraction is run both with and without a borrow, and with equal operands. These cases expose a carry-in stuck at 0, or a borrow flag with the wrong polarity. The bench also enables two drivers at once, which catches a priority mux that lets one result win where the bus should be released. Finally, it asserts reset in the same cycle as a load, which catches a design that lets the load win over reset.

// File: rtl/aluPkg.sv
package aluPkg;
  localparam int unsigned NUM_DRV  = 4;
  localparam int unsigned DRV_SUM  = 0;
  localparam int unsigned DRV_INV  = 1;
  localparam int unsigned DRV_AND  = 2;
  localparam int unsigned DRV_FLAG = 3;

  typedef struct packed {
    logic               sub;
    logic               load;
    logic [NUM_DRV-1:0] drive;
  } aluStrobes_t;
endpackage

// File: rtl/aluControl.sv
module aluControl
  import aluPkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        subMode,
  input  logic        sumEn,
  input  logic        invEn,
  input  logic        andEn,
  input  logic        flagEn,
  input  logic        flagLoad,
  output aluStrobes_t strobes
);
  logic [NUM_DRV-1:0] rawDrive;
  logic               clash;

  assign rawDrive[DRV_SUM]  = sumEn;
  assign rawDrive[DRV_INV]  = invEn;
  assign rawDrive[DRV_AND]  = andEn;
  assign rawDrive[DRV_FLAG] = flagEn;

  // more than one request: clearing the lowest set bit leaves something
  assign clash = |(rawDrive & (rawDrive - NUM_DRV'(1)));

  always_comb begin
    strobes.sub   = subMode;
    strobes.load  = flagLoad;
    strobes.drive = clash ? '0 : rawDrive;
  end

  // R6
  clash_release_chk: assert property (@(posedge clk) disable iff (rst)
    ($countones(rawDrive) > 1) |-> (strobes.drive == '0));

  // R5
  idle_release_chk: assert property (@(posedge clk) disable iff (rst)
    (rawDrive == '0) |-> (strobes.drive == '0));
endmodule

// File: rtl/aluDatapath.sv
module aluDatapath
  import aluPkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned FLAG_W    = 4,
  parameter int unsigned CARRY_BIT = 0
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  aluStrobes_t      strobes,
  output logic             carryOut,
  output logic [WIDTH-1:0] driveVal,
  output logic             driveEn
);
  localparam int unsigned PAD_W = WIDTH - FLAG_W;

  logic [WIDTH-1:0]  bCond;
  logic [WIDTH-1:0]  sumW;
  logic [WIDTH-1:0]  andW;
  logic [WIDTH:0]    chain;
  logic [FLAG_W-1:0] statusQ;

  // XOR conditioning stage and ripple adder, one slice per bit
  assign chain[0] = strobes.sub;
  for (genvar i = 0; i < WIDTH; i++) begin : g_slice
    assign bCond[i]    = bIn[i] ^ strobes.sub;
    assign sumW[i]     = aIn[i] ^ bCond[i] ^ chain[i];
    assign chain[i+1]  = (aIn[i] & bCond[i]) | (chain[i] & (aIn[i] ^ bCond[i]));
    assign andW[i]     = aIn[i] & bIn[i];
  end
  assign carryOut = chain[WIDTH];

  // status register: only the carry bit is live
  for (genvar f = 0; f < FLAG_W; f++) begin : g_flag
    if (f == CARRY_BIT) begin : g_carry
      always_ff @(posedge clk) begin
        if (rst)               statusQ[f] <= 1'b0;
        else if (strobes.load) statusQ[f] <= carryOut;
      end
    end else begin : g_unused
      assign statusQ[f] = 1'b0;
    end
  end

  always_comb begin
    driveVal = '0;
    if (strobes.drive[DRV_SUM])  driveVal = driveVal | sumW;
    if (strobes.drive[DRV_INV])  driveVal = driveVal | bCond;
    if (strobes.drive[DRV_AND])  driveVal = driveVal | andW;
    if (strobes.drive[DRV_FLAG]) driveVal = driveVal | {{PAD_W{1'b0}}, statusQ};
  end
  assign driveEn = |strobes.drive;

  // R1
  add_result_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.sub |-> ({carryOut, sumW} == ({1'b0, aIn} + {1'b0, bIn})));

  // R2
  sub_result_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.sub |-> ((sumW == WIDTH'(aIn - bIn)) && (carryOut == (aIn >= bIn))));

  // R8
  carry_latch_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.load |=> (statusQ[CARRY_BIT] == $past(carryOut)));

  // R9
  carry_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !strobes.load |=> $stable(statusQ));

  // R10
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (statusQ == '0));
endmodule

// File: rtl/busAlu.sv
module busAlu
  import aluPkg::*;
#(
  parameter int unsigned WIDTH     = 8,
  parameter int unsigned FLAG_W    = 4,
  parameter int unsigned CARRY_BIT = 0
)(
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] aIn,
  input  logic [WIDTH-1:0] bIn,
  input  logic             subMode,
  input  logic             sumEn,
  input  logic             invEn,
  input  logic             andEn,
  input  logic             flagEn,
  input  logic             flagLoad,
  output logic             carryOut,
  inout  wire  [WIDTH-1:0] dataBus
);
  aluStrobes_t      strobes;
  logic [WIDTH-1:0] driveVal;
  logic             driveEn;

  aluControl u_ctrl (
    .clk(clk), .rst(rst), .subMode(subMode), .sumEn(sumEn), .invEn(invEn),
    .andEn(andEn), .flagEn(flagEn), .flagLoad(flagLoad), .strobes(strobes)
  );

  aluDatapath #(.WIDTH(WIDTH), .FLAG_W(FLAG_W), .CARRY_BIT(CARRY_BIT)) u_dp (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn), .strobes(strobes),
    .carryOut(carryOut), .driveVal(driveVal), .driveEn(driveEn)
  );

  assign dataBus = driveEn ? driveVal : {WIDTH{1'bz}};
endmodule

// File: tb/test_busAlu.sv
module test_busAlu;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] aIn = '0, bIn = '0;
  logic       subMode = 0, sumEn = 0, invEn = 0, andEn = 0, flagEn = 0, flagLoad = 0;
  logic       carryOut;
  wire  [7:0] dataBus;

  typedef struct {
    logic [7:0] expBus;
    logic       expCarry;
    string      tag;
  } item_t;

  item_t q[$];
  int    checks = 0;
  int    errors = 0;
  logic  modelFlag = 1'b0;

  always #5 clk = ~clk;

  busAlu i_busAlu (
    .clk(clk), .rst(rst), .aIn(aIn), .bIn(bIn), .subMode(subMode),
    .sumEn(sumEn), .invEn(invEn), .andEn(andEn), .flagEn(flagEn),
    .flagLoad(flagLoad), .carryOut(carryOut), .dataBus(dataBus)
  );

  task automatic drive(input logic r, input logic [7:0] a, input logic [7:0] b,
                       input logic s, input logic eS, input logic eI,
                       input logic eA, input logic eF, input logic ld,
                       input string tag);
    item_t it;
    logic [8:0] full;
    logic       c;
    int         n;
    @(posedge clk);
    #1;
    rst = r; aIn = a; bIn = b; subMode = s;
    sumEn = eS; invEn = eI; andEn = eA; flagEn = eF; flagLoad = ld;
    if (s) begin
      full = {1'b0, a} - {1'b0, b};
      c    = (a >= b);
    end else begin
      full = {1'b0, a} + {1'b0, b};
      c    = full[8];
    end
    n = int'(eS) + int'(eI) + int'(eA) + int'(eF);
    if (n != 1)  it.expBus = 8'hzz;
    else if (eS) it.expBus = full[7:0];
    else if (eI) it.expBus = s ? ~b : b;
    else if (eA) it.expBus = a & b;
    else         it.expBus = {7'b0, modelFlag};
    it.expCarry = c;
    it.tag = tag;
    q.push_back(it);
    if (r)       modelFlag = 1'b0;
    else if (ld) modelFlag = c;
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        it = q.pop_front();
        checks++;
        if (dataBus !== it.expBus) begin
          errors++;
          $display("FAIL %s bus: actual %h expected %h", it.tag, dataBus, it.expBus);
        end
        checks++;
        if (carryOut !== it.expCarry) begin
          errors++;
          $display("FAIL %s carry: actual %b expected %b", it.tag, carryOut, it.expCarry);
        end
      end
    end
  end

  initial begin : watchdog
    #200000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    //     rst a      b      sub sum inv and flg ld
    drive(1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, "R10 reset idle");
    drive(1, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, "R10 reset idle");
    drive(0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, "R10 flag after reset");
    drive(0, 8'h12, 8'h34, 0, 0, 0, 0, 0, 0, "R5 no enable");
    drive(0, 8'hEB, 8'hAD, 0, 1, 0, 0, 0, 0, "R1 EB+AD");
    drive(0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, "R9 no load keeps 0");
    drive(0, 8'hEB, 8'hAD, 0, 0, 0, 0, 1, 1, "R8 old flag in load cycle");
    drive(0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, "R7 flag set reads 01");
    drive(0, 8'hFF, 8'h01, 0, 1, 0, 0, 0, 0, "R1 FF+01 wrap");
    drive(0, 8'h05, 8'h03, 1, 1, 0, 0, 0, 1, "R2 05-03 no borrow");
    drive(0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, "R8 flag after sub no borrow");
    drive(0, 8'h03, 8'h05, 1, 1, 0, 0, 0, 1, "R2 03-05 borrow");
    drive(0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, "R8 flag after borrow");
    drive(0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, "R9 flag held");
    drive(0, 8'h77, 8'h77, 1, 1, 0, 0, 0, 0, "R2 equal operands");
    drive(0, 8'h00, 8'h5A, 1, 0, 1, 0, 0, 0, "R3 invert B");
    drive(0, 8'h00, 8'h5A, 0, 0, 1, 0, 0, 0, "R3 pass B");
    drive(0, 8'hF0, 8'h3C, 0, 0, 0, 1, 0, 0, "R4 AND");
    drive(0, 8'hF0, 8'h3C, 0, 1, 0, 1, 0, 0, "R6 sum+and clash");
    drive(0, 8'hF0, 8'h3C, 0, 0, 1, 0, 1, 0, "R6 inv+flag clash");
    drive(0, 8'h80, 8'h80, 0, 0, 0, 0, 0, 1, "R8 load carry 1");
    drive(0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, "R7 flag reads 01");
    drive(1, 8'h80, 8'h80, 0, 0, 0, 0, 0, 1, "R10 reset beats load");
    drive(0, 8'h00, 8'h00, 0, 0, 0, 0, 1, 0, "R10 flag cleared");
    drive(0, 8'h00, 8'h00, 0, 0, 0, 0, 0, 0, "R5 idle end");
    wait (q.size() == 0);
    @(posedge clk);
    #1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule